// File: doc/BRIEF.md
# Circular Event-Log Write Controller

This block turns a stream of time stamps into byte writes on a small event-log RAM that is filled as a ring. Each entry is a 16-bit elapsed-time stamp. It is written as two bytes on consecutive cycles: low byte first at the write pointer, then the high byte one address above. Two request streams feed the block. The first carries real events, each with its stamp. The second signals that the elapsed-time timer has rolled over. A rollover writes a marker entry of FFFFh.

The block keeps three readable values. The write pointer always names the address where the next low byte will go. After the ring has wrapped, it also names the oldest entry, which is the next one to be overwritten. A sticky flag records that the ring has wrapped at least once. An event counter counts real events only; rollover entries do not add to it. A clear command resets all three values and abandons any entry that is being written.

Both request inputs are valid/ready streams. A request is taken on a cycle where both valid and ready are high. A requester that sees ready low must keep valid high and its stamp unchanged until the request is taken. The block lowers ready only while it writes a low byte, and during a clear cycle. It can therefore accept a new entry every two cycles.

Top module: `evlog_writer`

## Requirements
- R1: After reset, and on the cycle after `clr` is high, `next_ptr` equals `LOG_BASE`, `event_count` is 0 and `log_wrapped` is 0. While `clr` is high, `wr_en` and both ready outputs are 0. A clear abandons any half-written entry, and no byte of that entry is written afterwards.
- R2: Suppose an entry is accepted at edge t and `next_ptr` is P when its write starts. In the cycle after t, the block writes the low stamp byte (bits 7:0) to address P. In the next cycle it writes the high stamp byte (bits 15:8) to address P+1.
- R3: Both ready outputs are 0 in exactly the cycles where a low byte is being written (and while `clr` is high). In a high-byte cycle a new entry can be accepted, and its low byte follows in the next cycle.
- R4: When `ovf_valid` and `rec_valid` are both high, the rollover request is taken first. `rec_ready` is 0 whenever `ovf_valid` is 1.
- R5: A rollover entry writes the byte FFh at both of its addresses.
- R6: When the high byte is written, `next_ptr` advances by 2. If the result would equal `LOG_BASE + LOG_BYTES`, it goes back to `LOG_BASE` instead. `log_wrapped` becomes 1 at that first wrap and stays 1 until reset or clear.
- R7: `event_count` increases by one when the high byte of an event entry is written. It does not change for rollover entries.
- R8: `event_count` saturates at its all-ones value (FFFFFFh at the default `CNT_W` of 24) and never wraps to zero.
- R9: Every accepted request, unless it is abandoned by a clear, produces exactly two byte writes. No request held valid is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clr | input | 1 | Clear log: reset the pointer, wrap flag and count, and abandon any write |
| rec_valid | input | 1 | Event request valid |
| rec_ready | output | 1 | Event request ready |
| rec_etc | input | 16 | Event time stamp |
| ovf_valid | input | 1 | Timer rollover request valid |
| ovf_ready | output | 1 | Timer rollover request ready |
| wr_en | output | 1 | RAM byte write enable |
| wr_addr | output | PTR_W | RAM byte address |
| wr_data | output | 8 | RAM write byte |
| next_ptr | output | PTR_W | Address of the next low byte; the oldest entry once wrapped |
| event_count | output | CNT_W | Events logged in this mission |
| log_wrapped | output | 1 | Sticky flag: the ring has wrapped |

## Verification
The assertions assume the following about the inputs:
- `LOG_BASE` and `LOG_BYTES` are even, and the log region fits within `PTR_W` bits.
- Requesters follow the stream rule: valid and stamp are held while ready is low.
- `clr` may arrive in any cycle, including in the middle of an entry.

The stimulus keeps to these rules. Its drivers change a request only after a handshake observed at the previous edge. It pulses `clr` sparsely during random traffic, with no clears during a long phase of back-to-back events. That phase drives the counter, reduced to 8 bits in the bench, into saturation.

// File: rtl/evlog_pkg.sv
package evlog_pkg;
  localparam int STAMP_W = 16;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LO   = 2'd1,
    PH_HI   = 2'd2
  } phase_t;

  typedef struct packed {
    logic [STAMP_W-1:0] stamp;
    logic               is_event;
  } entry_t;
endpackage

// File: rtl/evlog_sequencer.sv
module evlog_sequencer
  import evlog_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               rec_valid,
  output logic               rec_ready,
  input  logic [STAMP_W-1:0] rec_etc,
  input  logic               ovf_valid,
  output logic               ovf_ready,
  output logic               wr_en,
  output logic               wr_hi,
  output logic [7:0]         wr_data,
  output logic               commit,
  output logic               commit_event
);
  localparam logic [STAMP_W-1:0] ROLL_MARK = '1;

  phase_t phase_q, phase_d;
  entry_t held_q, held_d;
  logic   can_take, take_ovf, take_rec;

  assign can_take  = (phase_q != PH_LO) && !clr;
  assign ovf_ready = can_take;
  assign rec_ready = can_take && !ovf_valid;
  assign take_ovf  = ovf_valid && ovf_ready;
  assign take_rec  = rec_valid && rec_ready;

  always_comb begin
    phase_d = phase_q;
    held_d  = held_q;
    if (clr) begin
      phase_d = PH_IDLE;
    end else if (phase_q == PH_LO) begin
      phase_d = PH_HI;
    end else if (take_ovf) begin
      phase_d = PH_LO;
      held_d  = '{stamp: ROLL_MARK, is_event: 1'b0};
    end else if (take_rec) begin
      phase_d = PH_LO;
      held_d  = '{stamp: rec_etc, is_event: 1'b1};
    end else begin
      phase_d = PH_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      held_q  <= '0;
    end else begin
      phase_q <= phase_d;
      held_q  <= held_d;
    end
  end

  assign wr_en        = (phase_q != PH_IDLE) && !clr;
  assign wr_hi        = (phase_q == PH_HI);
  assign wr_data      = wr_hi ? held_q.stamp[15:8] : held_q.stamp[7:0];
  assign commit       = (phase_q == PH_HI) && !clr;
  assign commit_event = held_q.is_event;

  // R2
  lsb_then_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hi) |=> (clr || (wr_en && wr_hi)));
  // R3
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_hi) |-> (!rec_ready && !ovf_ready));
  // R4
  ovf_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_valid |-> !rec_ready);
  // R1
  clr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> (!wr_en && !rec_ready && !ovf_ready));
endmodule

// File: rtl/evlog_pointer.sv
module evlog_pointer #(
  parameter int                 PTR_W     = 16,
  parameter logic [PTR_W-1:0]   LOG_BASE  = '0,
  parameter int                 LOG_BYTES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             commit,
  input  logic             wr_hi,
  output logic [PTR_W-1:0] wr_addr,
  output logic [PTR_W-1:0] next_ptr,
  output logic             log_wrapped
);
  localparam logic [PTR_W-1:0] LAST_SLOT = LOG_BASE + PTR_W'(LOG_BYTES - 2);
  localparam logic [PTR_W-1:0] LIMIT     = LOG_BASE + PTR_W'(LOG_BYTES);

  logic [PTR_W-1:0] ptr_q;
  logic             wrap_q;
  logic             at_end;

  assign at_end = (ptr_q == LAST_SLOT);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      ptr_q  <= LOG_BASE;
      wrap_q <= 1'b0;
    end else if (commit) begin
      if (at_end) begin
        ptr_q  <= LOG_BASE;
        wrap_q <= 1'b1;
      end else begin
        ptr_q  <= ptr_q + PTR_W'(2);
      end
    end
  end

  assign wr_addr     = wr_hi ? ptr_q + PTR_W'(1) : ptr_q;
  assign next_ptr    = ptr_q;
  assign log_wrapped = wrap_q;

  // R6
  ptr_in_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (next_ptr >= LOG_BASE) && (next_ptr < LIMIT) && !next_ptr[0]);
  // R6
  wrap_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (log_wrapped && !clr) |=> log_wrapped);
  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !clr) |=> $stable(next_ptr));
endmodule

// File: rtl/evlog_counter.sv
module evlog_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             commit,
  input  logic             commit_event,
  output logic [CNT_W-1:0] event_count
);
  localparam logic [CNT_W-1:0] TOP = '1;

  logic [CNT_W-1:0] cnt_q;
  logic             bump;

  assign bump = commit && commit_event && (cnt_q != TOP);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt_q <= '0;
    else if (bump)     cnt_q <= cnt_q + CNT_W'(1);
  end

  assign event_count = cnt_q;

  // R8
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (event_count == TOP && !clr) |=> (event_count == TOP));
  // R7
  cnt_only_events_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(commit && commit_event) && !clr) |=> $stable(event_count));
  // R1
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (event_count == '0));
endmodule

// File: rtl/evlog_writer.sv
module evlog_writer
  import evlog_pkg::*;
#(
  parameter int               PTR_W     = 16,
  parameter logic [PTR_W-1:0] LOG_BASE  = '0,
  parameter int               LOG_BYTES = 32,
  parameter int               CNT_W     = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               rec_valid,
  output logic               rec_ready,
  input  logic [STAMP_W-1:0] rec_etc,
  input  logic               ovf_valid,
  output logic               ovf_ready,
  output logic               wr_en,
  output logic [PTR_W-1:0]   wr_addr,
  output logic [7:0]         wr_data,
  output logic [PTR_W-1:0]   next_ptr,
  output logic [CNT_W-1:0]   event_count,
  output logic               log_wrapped
);
  logic wr_hi, commit, commit_event;

  evlog_sequencer u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (clr),
    .rec_valid    (rec_valid),
    .rec_ready    (rec_ready),
    .rec_etc      (rec_etc),
    .ovf_valid    (ovf_valid),
    .ovf_ready    (ovf_ready),
    .wr_en        (wr_en),
    .wr_hi        (wr_hi),
    .wr_data      (wr_data),
    .commit       (commit),
    .commit_event (commit_event)
  );

  evlog_pointer #(
    .PTR_W     (PTR_W),
    .LOG_BASE  (LOG_BASE),
    .LOG_BYTES (LOG_BYTES)
  ) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (clr),
    .commit      (commit),
    .wr_hi       (wr_hi),
    .wr_addr     (wr_addr),
    .next_ptr    (next_ptr),
    .log_wrapped (log_wrapped)
  );

  evlog_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr          (clr),
    .commit       (commit),
    .commit_event (commit_event),
    .event_count  (event_count)
  );

  // R9
  write_addr_in_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((wr_addr >= LOG_BASE) &&
               (wr_addr < LOG_BASE + PTR_W'(LOG_BYTES))));
endmodule

// File: tb/evlog_writer_tb.sv
module evlog_writer_tb;
  localparam int              CLK_PERIOD = 10;
  localparam int              PTR_W      = 16;
  localparam logic [15:0]     BASE       = 16'h0040;
  localparam int              BYTES      = 32;
  localparam int              CNT_W      = 8;
  localparam int              CNT_MAX    = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr = 1'b0;
  logic rec_valid = 1'b0;
  logic [15:0] rec_etc = '0;
  logic ovf_valid = 1'b0;
  logic rec_ready, ovf_ready, wr_en, log_wrapped;
  logic [PTR_W-1:0] wr_addr, next_ptr;
  logic [7:0] wr_data;
  logic [CNT_W-1:0] event_count;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 0;
  bit allow_clr = 1;
  bit rec_fire = 0, ovf_fire = 0;

  typedef struct {
    int addr;
    int data;
    bit last;
    bit evt;
  } wr_t;
  wr_t q[$];
  int mptr = BASE;
  int mcnt = 0;
  bit mwrap = 0;
  int accepted = 0;
  int bytes_seen = 0;
  int abandoned = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evlog_writer #(
    .PTR_W (PTR_W), .LOG_BASE (BASE), .LOG_BYTES (BYTES), .CNT_W (CNT_W)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .clr (clr),
    .rec_valid (rec_valid), .rec_ready (rec_ready), .rec_etc (rec_etc),
    .ovf_valid (ovf_valid), .ovf_ready (ovf_ready),
    .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
    .next_ptr (next_ptr), .event_count (event_count), .log_wrapped (log_wrapped)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // Compare against the model, then step the model with the inputs of this cycle.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int er;
      er = (q.size() != 2) && !clr;
      check("R3 rec_ready", int'(rec_ready), er && !ovf_valid);
      check("R4 ovf_ready", int'(ovf_ready), er);
      check("R1/R9 wr_en", int'(wr_en), (q.size() > 0) && !clr);
      if (wr_en && q.size() > 0) begin
        check("R2 wr_addr", int'(wr_addr), q[0].addr);
        check(q[0].evt ? "R2 wr_data" : "R5 wr_data", int'(wr_data), q[0].data);
        bytes_seen++;
      end
      check("R6 next_ptr", int'(next_ptr), mptr);
      check("R6 log_wrapped", int'(log_wrapped), int'(mwrap));
      check(mcnt == CNT_MAX ? "R8 event_count" : "R7 event_count", int'(event_count), mcnt);
      rec_fire = rec_valid && rec_ready;
      ovf_fire = ovf_valid && ovf_ready;
      if (clr) begin
        abandoned += q.size();
        q.delete();
        mptr = BASE; mcnt = 0; mwrap = 0;
      end else begin
        if (q.size() > 0) begin
          wr_t e;
          e = q.pop_front();
          if (e.last) begin
            mptr += 2;
            if (mptr == BASE + BYTES) begin
              mptr = BASE;
              mwrap = 1;
            end
            if (e.evt && mcnt < CNT_MAX) mcnt++;
          end
        end
        if (er && ovf_valid) begin
          q.push_back('{mptr, 8'hFF, 1'b0, 1'b0});
          q.push_back('{mptr + 1, 8'hFF, 1'b1, 1'b0});
          accepted++;
        end else if (er && rec_valid) begin
          q.push_back('{mptr, int'(rec_etc[7:0]), 1'b0, 1'b1});
          q.push_back('{mptr + 1, int'(rec_etc[15:8]), 1'b1, 1'b1});
          accepted++;
        end
      end
    end else begin
      rec_fire = 0;
      ovf_fire = 0;
    end
  end

  task automatic drive(input int rec_pct, input int ovf_pct, input int clr_per_mil);
    @(posedge clk); #1;
    if (!rec_valid || rec_fire) begin
      rec_valid = ($urandom_range(99) < rec_pct);
      rec_etc   = 16'($urandom);
    end
    if (!ovf_valid || ovf_fire) ovf_valid = ($urandom_range(99) < ovf_pct);
    clr = allow_clr && ($urandom_range(999) < clr_per_mil);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 reset next_ptr", int'(next_ptr), BASE);
    check("R1 reset count", int'(event_count), 0);
    check("R1 reset wrapped", int'(log_wrapped), 0);
    check("R1 reset wr_en", int'(wr_en), 0);
    rst_n = 1'b1;
    // sparse traffic
    for (int i = 0; i < 400; i++) drive(30, 5, 5);
    // dense traffic with collisions and clears; wraps the ring many times
    for (int i = 0; i < 3000; i++) drive(90, 25, 8);
    // clear then back-to-back events only: saturate the counter (R8)
    allow_clr = 0;
    @(posedge clk); #1; clr = 1; rec_valid = 0; ovf_valid = 0;
    @(posedge clk); #1; clr = 0;
    for (int i = 0; i < 700; i++) drive(100, 0, 0);
    for (int i = 0; i < 60; i++) drive(60, 40, 0);
    rec_valid = 0; ovf_valid = 0;
    repeat (4) @(posedge clk);
    #1;
    check("R8 saturated", int'(event_count), CNT_MAX);
    // R9: every accepted request wrote exactly two bytes, except those a clear abandoned
    check("R9 byte total", bytes_seen + abandoned, 2 * accepted);
    // R1: clear mid-entry abandons the high byte
    rec_valid = 1; rec_etc = 16'hA55A;
    @(posedge clk); #1; rec_valid = 0;
    check("R1 low byte write", int'(wr_en), 1);
    clr = 1;
    @(posedge clk); #1; clr = 0;
    check("R1 no write after clear", int'(wr_en), 0);
    check("R1 ptr after clear", int'(next_ptr), BASE);
    check("R1 count after clear", int'(event_count), 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule